// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address by reading two levels of translation entries from memory. It accepts one translation at a time. Each translation carries the virtual address, a read/write flag and a user/supervisor flag. The block samples the directory base address when it accepts the request. It reads the directory entry selected by address bits 31:22, then the table entry selected by bits 21:12. Bits 11:0 pass through unchanged as the offset inside a 4 KB frame.

Each level is checked for presence and permission before the walk continues. A failed check ends the walk with a page-fault result. That result holds a three-bit error code, a latched copy of the faulting virtual address and the exception vector 0x0E. When a walk succeeds, the block writes back the accessed flag in each entry that lacks it. On a write access it also sets the dirty flag in the table entry.

Memory access uses a valid/ready request channel. A read is answered later by a single-cycle response strobe that carries the data. A write is complete when the request is accepted.

Top module: `pt_walker`

## Requirements
- R1: Once a request has been accepted, the first memory request is a read (`mem_req_write`=0) at address `dir_base + 4*vaddr[31:22]`.
- R2: If the directory entry passes its checks, the next memory request is a read at `{pde[31:12],12'b0} + 4*vaddr[21:12]`.
- R3: On success, `done` pulses with `done_fault`=0 and `done_paddr = {pte[31:12], vaddr[11:0]}`.
- R4: If an entry has bit 0 (present) clear, the walk faults with error code bit 0 = 0. If the directory entry is not present, no table read is issued.
- R5: A user access (`req_user`=1) faults with code bit 0 = 1 when the entry bit 2 (user) is clear. The directory entry is checked alone first. The table level then checks the AND of the user bits of both entries.
- R6: A user write faults with code bit 0 = 1 when bit 1 (writable) is clear. As in R5, the AND of both levels applies at the table level. Supervisor accesses ignore the writable bit.
- R7: The error code is `{user, write, present}` in bits 2:0: bit 2 = `req_user`, bit 1 = `req_write`, bit 0 = 1 for a protection fault and 0 for a not-present fault.
- R8: On a fault, `fault_vaddr` captures the request's virtual address and `fault_vector` reads 8'h0E. Both hold their values across later successful walks.
- R9: After a successful walk, bit 5 (accessed) is set in both entries in memory. An entry that already has bit 5 set is not rewritten.
- R10: After a successful write access, bit 6 (dirty) is set in the table entry. A read access leaves bit 6 unchanged. A fault changes neither entry.
- R11: `busy` is high from the cycle after acceptance until `done`. While busy, `req_valid` is ignored. A memory request that is not accepted holds its address, data and direction.
- R12: After reset, `busy`, `done`, `mem_req_valid` and `fault_vector` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe, accepted when idle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access |
| req_user | input | 1 | 1 = user-level access |
| dir_base | input | 32 | Page-aligned physical base of the directory |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result strobe |
| done_fault | output | 1 | Result is a page fault |
| done_paddr | output | 32 | Translated physical address |
| fault_code | output | 3 | Error code of the last fault |
| fault_vaddr | output | 32 | Virtual address of the last fault |
| fault_vector | output | 8 | Exception vector of the last fault |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = entry write-back, 0 = entry read |
| mem_req_addr | output | 32 | Entry byte address |
| mem_req_wdata | output | 32 | Write-back data |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_rdata | input | 32 | Read data |

## Verification
The assertions assume that the memory answers each accepted read with exactly one `mem_rsp_valid` pulse. They also assume that no response arrives unless a read is outstanding, and that `dir_base` has its low 12 bits clear. The bench memory model produces one response per captured read handshake, after a delay of zero or one extra cycle. It varies ready from a shift register, and it uses only page-aligned bases. The stimulus sweeps every combination of present, writable and user bits at both levels, crossed with read/write and user/supervisor. Across that sweep the accessed and dirty presets and the indices are varied. In some walks a stray request is also raised while the block is busy.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int ENT_P = 0;
  localparam int ENT_W = 1;
  localparam int ENT_U = 2;
  localparam int ENT_A = 5;
  localparam int ENT_D = 6;
  localparam logic [7:0] PF_VECTOR = 8'h0E;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_RD,
    ST_DIR_WT,
    ST_TBL_RD,
    ST_TBL_WT,
    ST_DIR_WB,
    ST_TBL_WB
  } walk_state_t;
endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
  parameter int AW    = 32,
  parameter int IDX_W = 10
) (
  input  logic [AW-1:0]    base,
  input  logic [IDX_W-1:0] idx,
  output logic [AW-1:0]    addr
);
  localparam int ENTRY_SHIFT = 2;
  always_comb addr = base + (AW'(idx) << ENTRY_SHIFT);
endmodule

// File: rtl/ptw_perm.sv
module ptw_perm (
  input  logic [2:0] dir_flags,
  input  logic [2:0] tbl_flags,
  input  logic       at_table,
  input  logic       is_write,
  input  logic       is_user,
  output logic       fault,
  output logic [2:0] code
);
  import ptw_pkg::*;
  logic present, w_eff, u_eff, viol;
  always_comb begin
    present = at_table ? tbl_flags[ENT_P] : dir_flags[ENT_P];
    w_eff   = dir_flags[ENT_W] & (at_table ? tbl_flags[ENT_W] : 1'b1);
    u_eff   = dir_flags[ENT_U] & (at_table ? tbl_flags[ENT_U] : 1'b1);
    viol    = is_user & (~u_eff | (is_write & ~w_eff));
    fault   = ~present | viol;
    code    = {is_user, is_write, present};
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int AW    = 32,
  parameter int OFF_W = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_vaddr,
  input  logic          req_write,
  input  logic          req_user,
  input  logic [AW-1:0] dir_base,
  output logic          busy,
  output logic          done,
  output logic          done_fault,
  output logic [AW-1:0] done_paddr,
  output logic [2:0]    fault_code,
  output logic [AW-1:0] fault_vaddr,
  output logic [7:0]    fault_vector,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [AW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [AW-1:0] mem_rsp_rdata
);
  import ptw_pkg::*;
  localparam int IDX_W  = OFF_W - 2;
  localparam int FRM_W  = AW - OFF_W;
  localparam int DIR_LO = OFF_W + IDX_W;

  walk_state_t   state;
  logic [AW-1:0] va_q, base_q, pde_q, pte_q;
  logic          wr_q, usr_q;
  logic [AW-1:0] dir_addr, tbl_addr, tbl_base;
  logic [AW-1:0] pde_cur;
  logic          chk_fault;
  logic [2:0]    chk_code;
  logic          dir_wb_need, tbl_wb_need_rsp, tbl_wb_need_q;

  assign tbl_base = {pde_q[AW-1:OFF_W], {OFF_W{1'b0}}};

  ptw_entry_addr #(.AW(AW), .IDX_W(IDX_W)) u_dir_addr (
    .base(base_q), .idx(va_q[AW-1:DIR_LO]), .addr(dir_addr));
  ptw_entry_addr #(.AW(AW), .IDX_W(IDX_W)) u_tbl_addr (
    .base(tbl_base), .idx(va_q[DIR_LO-1:OFF_W]), .addr(tbl_addr));

  assign pde_cur = (state == ST_DIR_WT) ? mem_rsp_rdata : pde_q;

  ptw_perm u_perm (
    .dir_flags(pde_cur[2:0]),
    .tbl_flags(mem_rsp_rdata[2:0]),
    .at_table (state == ST_TBL_WT),
    .is_write (wr_q),
    .is_user  (usr_q),
    .fault    (chk_fault),
    .code     (chk_code)
  );

  assign dir_wb_need     = ~pde_q[ENT_A];
  assign tbl_wb_need_rsp = ~mem_rsp_rdata[ENT_A] | (wr_q & ~mem_rsp_rdata[ENT_D]);
  assign tbl_wb_need_q   = ~pte_q[ENT_A] | (wr_q & ~pte_q[ENT_D]);

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = dir_addr;
    mem_req_wdata = '0;
    case (state)
      ST_DIR_RD: mem_req_valid = 1'b1;
      ST_TBL_RD: begin mem_req_valid = 1'b1; mem_req_addr = tbl_addr; end
      ST_DIR_WB: begin
        mem_req_valid = 1'b1; mem_req_write = 1'b1;
        mem_req_wdata = pde_q | (AW'(1) << ENT_A);
      end
      ST_TBL_WB: begin
        mem_req_valid = 1'b1; mem_req_write = 1'b1; mem_req_addr = tbl_addr;
        mem_req_wdata = pte_q | (AW'(1) << ENT_A) | (AW'(wr_q) << ENT_D);
      end
      default: ;
    endcase
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      va_q         <= '0;
      base_q       <= '0;
      pde_q        <= '0;
      pte_q        <= '0;
      wr_q         <= 1'b0;
      usr_q        <= 1'b0;
      done         <= 1'b0;
      done_fault   <= 1'b0;
      done_paddr   <= '0;
      fault_code   <= '0;
      fault_vaddr  <= '0;
      fault_vector <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          wr_q   <= req_write;
          usr_q  <= req_user;
          base_q <= dir_base;
          state  <= ST_DIR_RD;
        end
        ST_DIR_RD: if (mem_req_ready) state <= ST_DIR_WT;
        ST_TBL_RD: if (mem_req_ready) state <= ST_TBL_WT;
        ST_DIR_WT, ST_TBL_WT: if (mem_rsp_valid) begin
          if (state == ST_DIR_WT) pde_q <= mem_rsp_rdata;
          else                    pte_q <= mem_rsp_rdata;
          if (chk_fault) begin
            done         <= 1'b1;
            done_fault   <= 1'b1;
            fault_code   <= chk_code;
            fault_vaddr  <= va_q;
            fault_vector <= PF_VECTOR;
            state        <= ST_IDLE;
          end else if (state == ST_DIR_WT) begin
            state <= ST_TBL_RD;
          end else if (dir_wb_need) begin
            state <= ST_DIR_WB;
          end else if (tbl_wb_need_rsp) begin
            state <= ST_TBL_WB;
          end else begin
            done       <= 1'b1;
            done_fault <= 1'b0;
            done_paddr <= {mem_rsp_rdata[AW-1:OFF_W], va_q[OFF_W-1:0]};
            state      <= ST_IDLE;
          end
        end
        ST_DIR_WB: if (mem_req_ready) begin
          if (tbl_wb_need_q) state <= ST_TBL_WB;
          else begin
            done       <= 1'b1;
            done_fault <= 1'b0;
            done_paddr <= {pte_q[AW-1:OFF_W], va_q[OFF_W-1:0]};
            state      <= ST_IDLE;
          end
        end
        ST_TBL_WB: if (mem_req_ready) begin
          done       <= 1'b1;
          done_fault <= 1'b0;
          done_paddr <= {pte_q[AW-1:OFF_W], va_q[OFF_W-1:0]};
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11: an unaccepted memory request keeps its content
  assert_req_stable_R11: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata));

  // R11: result strobe only when the walk has ended
  assert_done_idle_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && !mem_req_valid);

  // R3: offset passes through untouched
  assert_offset_R3: assert property (@(posedge clk) disable iff (rst)
    done && !done_fault |-> done_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]);

  // R8: fault captures the request address and vector
  assert_fault_capture_R8: assert property (@(posedge clk) disable iff (rst)
    done && done_fault |-> fault_vaddr == va_q && fault_vector == PF_VECTOR);

  // R7: error code reflects access type and privilege
  assert_code_bits_R7: assert property (@(posedge clk) disable iff (rst)
    done && done_fault |-> fault_code[2] == usr_q && fault_code[1] == wr_q);

  // R9: every write-back carries present and accessed
  assert_wb_flags_R9: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && mem_req_write |-> mem_req_wdata[ENT_A] && mem_req_wdata[ENT_P]);

  // R4: a table read needs a present directory entry
  assert_dir_present_R4: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_write && mem_req_addr == tbl_addr && state == ST_TBL_RD
      |-> pde_q[ENT_P]);
endmodule

// File: tb/pt_walker_test.sv
module pt_walker_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_vaddr = '0, dir_base = 32'h0000_1000;
  logic        busy, done, done_fault;
  logic [31:0] done_paddr, fault_vaddr;
  logic [2:0]  fault_code;
  logic [7:0]  fault_vector;
  logic        mem_req_valid, mem_req_write;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;

  pt_walker uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user), .dir_base(dir_base),
    .busy(busy), .done(done), .done_fault(done_fault), .done_paddr(done_paddr),
    .fault_code(fault_code), .fault_vaddr(fault_vaddr), .fault_vector(fault_vector),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata)
  );

  logic [31:0] mem [0:4095];
  int checks = 0, failures = 0;
  int tbl_reads = 0;

  // memory model: handshake captured at posedge, effect applied at negedge
  logic        acc_v = 1'b0, acc_w = 1'b0;
  logic [31:0] acc_a = '0, acc_d = '0;
  always @(posedge clk) begin
    acc_v <= mem_req_valid && mem_req_ready;
    acc_w <= mem_req_write;
    acc_a <= mem_req_addr;
    acc_d <= mem_req_wdata;
  end

  logic [15:0] lfsr = 16'hACE1;
  logic        pend = 1'b0;
  logic        pdly = 1'b0;
  logic [31:0] paddr_q = '0;
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_req_ready <= lfsr[0] | lfsr[3];
    mem_rsp_valid <= 1'b0;
    if (acc_v) begin
      if (acc_w) mem[acc_a[13:2]] = acc_d;
      else begin pend = 1'b1; pdly = lfsr[5]; paddr_q = acc_a; end
    end
    if (pend) begin
      if (!pdly) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= mem[paddr_q[13:2]];
        pend = 1'b0;
      end else pdly = 1'b0;
    end
  end

  always @(posedge clk)
    if (!rst && mem_req_valid && mem_req_ready && !mem_req_write && mem_req_addr >= 32'h2000)
      tbl_reads <= tbl_reads + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] last_fva;
    logic [7:0]  last_vec;
    for (int k = 0; k < 4096; k++) mem[k] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12: reset state
    chk(!busy, "R12 busy", {31'b0, busy}, 0);
    chk(!done, "R12 done", {31'b0, done}, 0);
    chk(!mem_req_valid, "R12 mem_req_valid", {31'b0, mem_req_valid}, 0);
    chk(fault_vector == 8'h00, "R12 fault_vector", {24'b0, fault_vector}, 0);
    last_fva = '0;
    last_vec = 8'h00;

    for (int i = 0; i < 256; i++) begin
      logic [2:0]  dflg, tflg;
      logic        wr, us, pa, ta, td;
      logic [9:0]  pdi, pti;
      logic [11:0] off;
      logic [19:0] frame;
      logic [31:0] tb, pde, pte, va, exp_pde, exp_pte;
      int          di, ti, rd_before;
      logic        e_fault;
      logic [2:0]  e_code;
      logic        e_tblrd;
      dflg = i[2:0]; tflg = i[5:3]; wr = i[6]; us = i[7];
      pa = ((i / 5) % 2) == 1; ta = ((i / 7) % 2) == 1; td = ((i / 11) % 2) == 1;
      pdi = 10'((i * 37) % 1024); pti = 10'((i * 53 + 7) % 1024);
      off = 12'((i * 97) % 4096); frame = 20'(i * 12345 + 1);
      tb  = (((i / 3) % 2) == 1) ? 32'h3000 : 32'h2000;
      pde = tb | {25'b0, 1'b0, pa, 2'b0, dflg};
      pte = {frame, 5'b0, td, ta, 2'b0, tflg};
      di = int'((dir_base + {20'b0, pdi, 2'b00}) >> 2) & 4095;
      ti = int'((tb + {20'b0, pti, 2'b00}) >> 2) & 4095;
      mem[di] = pde; mem[ti] = pte;
      va = {pdi, pti, off};

      // independent expectation
      e_tblrd = 1'b0;
      exp_pde = pde; exp_pte = pte;
      if (!dflg[0]) begin e_fault = 1; e_code = {us, wr, 1'b0}; end
      else if (us && (!dflg[2] || (wr && !dflg[1]))) begin e_fault = 1; e_code = {us, wr, 1'b1}; end
      else begin
        e_tblrd = 1'b1;
        if (!tflg[0]) begin e_fault = 1; e_code = {us, wr, 1'b0}; end
        else if (us && (!(dflg[2] & tflg[2]) || (wr && !(dflg[1] & tflg[1])))) begin
          e_fault = 1; e_code = {us, wr, 1'b1};
        end else begin
          e_fault = 0; e_code = 3'b000;
          exp_pde = pde | 32'h20;
          exp_pte = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
        end
      end

      rd_before = tbl_reads;
      req_vaddr = va; req_write = wr; req_user = us; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy, "R11 busy after accept", {31'b0, busy}, 1);
      if (i % 4 == 0) begin
        req_vaddr = ~va; req_write = ~wr; req_user = ~us; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
      end
      while (!done) @(negedge clk);

      chk(done_fault == e_fault, "R4/R5/R6 fault flag", {31'b0, done_fault}, {31'b0, e_fault});
      if (e_fault) begin
        chk(fault_code == e_code, "R7 error code", {29'b0, fault_code}, {29'b0, e_code});
        chk(fault_vaddr == va, "R8 fault vaddr", fault_vaddr, va);
        chk(fault_vector == 8'h0E, "R8 vector", {24'b0, fault_vector}, 32'h0E);
        last_fva = va; last_vec = 8'h0E;
        if (!dflg[0])
          chk(tbl_reads == rd_before, "R4 no table read", tbl_reads, rd_before);
      end else begin
        chk(done_paddr == {frame, off}, "R1/R2/R3 paddr", done_paddr, {frame, off});
        chk(fault_vaddr == last_fva && fault_vector == last_vec, "R8 fault regs held",
            fault_vaddr, last_fva);
      end
      chk((tbl_reads != rd_before) == e_tblrd, "R2 table read issued",
          tbl_reads - rd_before, {31'b0, e_tblrd});
      @(negedge clk);
      chk(mem[di] == exp_pde, "R9 directory entry", mem[di], exp_pde);
      chk(mem[ti] == exp_pte, "R9/R10 table entry", mem[ti], exp_pte);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule